// File: doc/BRIEF.md
# Write-Back Invalidate Snooping Cache Controller

This block is the coherence controller of one private, direct-mapped, write-back cache on a shared bus. Every bus transaction is atomic and completes in the cycle it is granted. Each cache line holds one data word, a tag and one of three states: Invalid, Shared (clean and read-only) or Exclusive (the only copy, dirty and writable). The processor side accepts one load or store at a time and holds the request until a completion pulse. Read hits, and write hits on Exclusive lines, finish without any bus traffic. All other accesses go to the bus as a read miss or a write miss. When the line still holds a different, dirty block, that block is written back first.

The same controller watches the misses that other caches place on the bus. When a snooped miss names a block this cache holds Exclusive, the controller raises an abort so that memory does not answer, and it drives the line's data onto the bus. A snooped read miss then leaves the line Shared. A snooped write miss leaves it Invalid, and it also invalidates a Shared copy. Arbitration is outside the block and appears only as a grant input.

Top module: `snoopy_wb_ctrl`

## Requirements
- R1: After reset every line is Invalid, and `bus_req`, `cpu_done` and `snp_abort` are low. The first access to any address therefore goes to the bus.
- R2: A processor read to a line that is Invalid, or that holds another clean block, requests the bus with command 2'b01 (read miss) and the requested address. On grant the line is filled from `bus_rdata` and becomes Shared, and `cpu_rdata` returns the filled word.
- R3: A processor write to a line that is Invalid, or Shared, or that holds another clean block, requests the bus with command 2'b10 (write miss). On grant the line takes the write data and becomes Exclusive.
- R4: A read that hits in Shared or Exclusive, and a write that hits in Exclusive, use no bus cycle. `cpu_done` rises one cycle after the request is accepted, and a read returns the stored word.
- R5: A read miss on a line whose Exclusive block has another tag first issues command 2'b11 (write-back) with the victim's address and data. It then issues the read miss and ends Shared.
- R6: A write miss on a line whose Exclusive block has another tag issues the write-back first, then the write miss, and ends Exclusive with the new data.
- R7: A snooped read miss (`snp_cmd` 2'b01) that matches a valid Exclusive line raises `snp_abort` in the same cycle and drives the line word on `snp_data`. The line then becomes Shared, so a later processor write needs a write miss.
- R8: A snooped write miss (`snp_cmd` 2'b10) that matches an Exclusive line raises `snp_abort` with the line data and invalidates the line. One that matches a Shared line only invalidates it, with no abort.
- R9: A snoop takes effect only when the line is valid and its tag equals the snooped tag. Otherwise it changes nothing and `snp_abort` stays low (and `snp_data` is zero). A snooped read miss on a Shared line also leaves it Shared.
- R10: When `snp_valid` is high in the same cycle that an idle controller sees a processor request, the snoop is handled and the request is accepted one cycle later.
- R11: `bus_req` stays high with a stable command and address until a cycle with `bus_gnt`, unless a snoop changes the victim. `cpu_done` is a one-cycle pulse in the cycle after the final grant.
- R12: If a snoop cleans the victim while the write-back waits for a grant, the write-back is dropped and only the miss is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req | input | 1 | Processor request, held until `cpu_done` |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | Word address; the low IDX_W bits select the line |
| cpu_wdata | input | DATA_W | Store data |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | DATA_W | Load result, valid with `cpu_done` |
| bus_req | output | 1 | Request for a bus transaction |
| bus_cmd | output | 2 | 01 read miss, 10 write miss, 11 write-back |
| bus_addr | output | ADDR_W | Transaction address |
| bus_wdata | output | DATA_W | Write-back data (zero for misses) |
| bus_gnt | input | 1 | Grant; the transaction completes in this cycle |
| bus_rdata | input | DATA_W | Fill data for a granted read miss |
| snp_valid | input | 1 | Another cache's transaction is on the bus |
| snp_cmd | input | 2 | Command of the snooped transaction |
| snp_addr | input | ADDR_W | Address of the snooped transaction |
| snp_abort | output | 1 | Cancel the memory response; this cache supplies data |
| snp_data | output | DATA_W | Supplied line data while `snp_abort` is high |

## Verification
Snoop responses are combinational: `snp_abort` and `snp_data` are due in the same cycle as `snp_valid`, and the state change they cause is visible from the next cycle. A hit completes with `cpu_done` one cycle after acceptance. A miss completes one cycle after the grant of its last transaction, so an extra write-back or a deferring snoop adds exactly its own cycles. The bench drives every input shortly after the falling edge, and it samples all outputs a few nanoseconds later, after they have settled. A behavioural model, advanced on each rising edge, predicts every output for that window. Directed checks also compare latency counts and the log of granted commands against these cycle budgets.

// File: rtl/snc_pkg.sv
// Shared types for the snooping write-back cache controller.
// Assumes a single-word line and a two-bit bus command field.
package snc_pkg;

    // Coherence state kept per cache line.
    typedef enum logic [1:0] {
        LS_INV = 2'b00,
        LS_SHR = 2'b01,
        LS_EXC = 2'b10
    } line_st_t;

    // Command carried on the shared bus.
    typedef enum logic [1:0] {
        BC_NONE  = 2'b00,
        BC_RDMIS = 2'b01,
        BC_WRMIS = 2'b10,
        BC_WBACK = 2'b11
    } bus_cmd_t;

    // Processor-side sequencing.
    typedef enum logic [1:0] {
        PS_IDLE,
        PS_WBACK,
        PS_MISS,
        PS_DONE
    } proc_st_t;

endpackage

// File: rtl/snc_line_store.sv
// Tag, state and data arrays of a direct-mapped cache.
// Port A serves the processor side and port B serves the snoop side.
// Both ports read combinationally and write at the clock edge. When both
// write the state of the same line in one cycle, the snoop write wins.
// Tags and data need no reset, because an Invalid state masks them.
module snc_line_store
    import snc_pkg::*;
#(
    parameter int IDX_W  = 2,
    parameter int TAG_W  = 10,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  a_idx,
    output logic [TAG_W-1:0]  a_tag,
    output line_st_t          a_st,
    output logic [DATA_W-1:0] a_data,
    input  logic              a_we_st,
    input  logic              a_we_tag,
    input  logic              a_we_data,
    input  line_st_t          a_wst,
    input  logic [TAG_W-1:0]  a_wtag,
    input  logic [DATA_W-1:0] a_wdata,
    input  logic [IDX_W-1:0]  b_idx,
    output logic [TAG_W-1:0]  b_tag,
    output line_st_t          b_st,
    output logic [DATA_W-1:0] b_data,
    input  logic              b_we_st,
    input  line_st_t          b_wst
);
    localparam int LINES = 1 << IDX_W;

    line_st_t          st_q   [LINES];
    logic [TAG_W-1:0]  tag_q  [LINES];
    logic [DATA_W-1:0] data_q [LINES];

    // Combinational read ports.
    assign a_tag  = tag_q[a_idx];
    assign a_st   = st_q[a_idx];
    assign a_data = data_q[a_idx];
    assign b_tag  = tag_q[b_idx];
    assign b_st   = st_q[b_idx];
    assign b_data = data_q[b_idx];

    // State array: reset to Invalid; the snoop write is placed last so it wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < LINES; i++) st_q[i] <= LS_INV;
        end else begin
            if (a_we_st) st_q[a_idx] <= a_wst;
            if (b_we_st) st_q[b_idx] <= b_wst;
        end
    end

    // Tag and data arrays, written only by the processor side.
    always_ff @(posedge clk) begin
        if (a_we_tag)  tag_q[a_idx]  <= a_wtag;
        if (a_we_data) data_q[a_idx] <= a_wdata;
    end

endmodule

// File: rtl/snc_snoop.sv
// Snoop responder. It decides, in the same cycle, how a transaction issued
// by another cache affects the addressed line. A snoop acts only on a valid
// line whose tag matches. A dirty hit cancels the memory response and
// drives the line data on the bus.
// Assumes the line read port is indexed by the snooped address.
module snc_snoop
    import snc_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int IDX_W  = 2,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              snp_valid,
    input  logic [1:0]        snp_cmd,
    input  logic [ADDR_W-1:0] snp_addr,
    input  logic [ADDR_W-IDX_W-1:0] line_tag,
    input  line_st_t          line_st,
    input  logic [DATA_W-1:0] line_data,
    output logic              upd_we,
    output line_st_t          upd_st,
    output logic              snp_abort,
    output logic [DATA_W-1:0] snp_data
);
    localparam int TAG_W = ADDR_W - IDX_W;

    logic [TAG_W-1:0] snp_tag;
    logic             hit;
    logic             dirty_hit;
    bus_cmd_t         cmd;

    assign snp_tag = snp_addr[ADDR_W-1:IDX_W];
    assign cmd     = bus_cmd_t'(snp_cmd);

    // Match qualification: valid line and equal tag.
    always_comb begin
        hit       = snp_valid && (line_st != LS_INV) && (line_tag == snp_tag);
        dirty_hit = hit && (line_st == LS_EXC);
    end

    // State update and data supply for matched misses.
    always_comb begin
        upd_we    = 1'b0;
        upd_st    = line_st;
        snp_abort = 1'b0;
        snp_data  = '0;
        if (hit && cmd == BC_RDMIS && dirty_hit) begin
            upd_we    = 1'b1;
            upd_st    = LS_SHR;
            snp_abort = 1'b1;
            snp_data  = line_data;
        end else if (hit && cmd == BC_WRMIS) begin
            upd_we    = 1'b1;
            upd_st    = LS_INV;
            snp_abort = dirty_hit;
            snp_data  = dirty_hit ? line_data : '0;
        end
    end

    AST_ABORT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        snp_abort |=> !(snp_valid && snp_addr == $past(snp_addr) && line_st == LS_EXC)); // R7

endmodule

// File: rtl/snc_proc_fsm.sv
// Processor-side sequencer. It looks up the addressed line, completes hits
// locally, and otherwise runs an optional victim write-back followed by a
// read or write miss on the bus.
// Assumes the processor holds its request until cpu_done, that a granted
// transaction completes in its grant cycle, and that no grant arrives in a
// snoop cycle. A snoop in the idle cycle defers acceptance of a request.
module snc_proc_fsm
    import snc_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int IDX_W  = 2,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_done,
    output logic [DATA_W-1:0] cpu_rdata,
    input  logic              snp_valid,
    input  logic [ADDR_W-IDX_W-1:0] line_tag,
    input  line_st_t          line_st,
    input  logic [DATA_W-1:0] line_data,
    output logic              bus_req,
    output bus_cmd_t          bus_cmd,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_gnt,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic              wr_st,
    output logic              wr_tag,
    output logic              wr_data,
    output line_st_t          wr_st_val,
    output logic [DATA_W-1:0] wr_data_val
);
    localparam int TAG_W = ADDR_W - IDX_W;

    proc_st_t          fsm_q, fsm_d;
    logic [DATA_W-1:0] rdata_q;
    logic [TAG_W-1:0]  req_tag;
    logic [IDX_W-1:0]  req_idx;
    logic              tag_eq, rd_hit, wr_hit, victim_dirty, accept, hit;

    assign req_tag = cpu_addr[ADDR_W-1:IDX_W];
    assign req_idx = cpu_addr[IDX_W-1:0];

    // Lookup of the addressed line.
    always_comb begin
        tag_eq       = (line_tag == req_tag);
        rd_hit       = (line_st != LS_INV) && tag_eq;
        wr_hit       = (line_st == LS_EXC) && tag_eq;
        victim_dirty = (line_st == LS_EXC) && !tag_eq;
        hit          = cpu_we ? wr_hit : rd_hit;
        accept       = (fsm_q == PS_IDLE) && cpu_req && !snp_valid;
    end

    // Next-state selection.
    always_comb begin
        fsm_d = fsm_q;
        unique case (fsm_q)
            PS_IDLE:  if (accept) fsm_d = hit ? PS_DONE : (victim_dirty ? PS_WBACK : PS_MISS);
            PS_WBACK: if (!victim_dirty || bus_gnt) fsm_d = PS_MISS;
            PS_MISS:  if (bus_gnt) fsm_d = PS_DONE;
            PS_DONE:  fsm_d = PS_IDLE;
            default:  fsm_d = PS_IDLE;
        endcase
    end

    // Bus request fields for the write-back and miss phases.
    always_comb begin
        bus_req   = 1'b0;
        bus_cmd   = BC_NONE;
        bus_addr  = '0;
        bus_wdata = '0;
        if (fsm_q == PS_WBACK && victim_dirty) begin
            bus_req   = 1'b1;
            bus_cmd   = BC_WBACK;
            bus_addr  = {line_tag, req_idx};
            bus_wdata = line_data;
        end else if (fsm_q == PS_MISS) begin
            bus_req  = 1'b1;
            bus_cmd  = cpu_we ? BC_WRMIS : BC_RDMIS;
            bus_addr = cpu_addr;
        end
    end

    // Line-store writes for write hits, victim release and miss fills.
    always_comb begin
        wr_st       = 1'b0;
        wr_tag      = 1'b0;
        wr_data     = 1'b0;
        wr_st_val   = line_st;
        wr_data_val = cpu_wdata;
        if (accept && hit && cpu_we) begin
            wr_data = 1'b1;
        end else if (fsm_q == PS_WBACK && victim_dirty && bus_gnt) begin
            wr_st     = 1'b1;
            wr_st_val = LS_INV;
        end else if (fsm_q == PS_MISS && bus_gnt) begin
            wr_st       = 1'b1;
            wr_tag      = 1'b1;
            wr_data     = 1'b1;
            wr_st_val   = cpu_we ? LS_EXC : LS_SHR;
            wr_data_val = cpu_we ? cpu_wdata : bus_rdata;
        end
    end

    // Sequencer state register.
    always_ff @(posedge clk) begin
        if (!rst_n) fsm_q <= PS_IDLE;
        else        fsm_q <= fsm_d;
    end

    // Load result capture on a read hit or a read fill.
    always_ff @(posedge clk) begin
        if (!rst_n)                                          rdata_q <= '0;
        else if (accept && hit && !cpu_we)                   rdata_q <= line_data;
        else if (fsm_q == PS_MISS && bus_gnt && !cpu_we)     rdata_q <= bus_rdata;
    end

    assign cpu_done  = (fsm_q == PS_DONE);
    assign cpu_rdata = rdata_q;

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_done |=> !cpu_done); // R11
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_gnt && !snp_valid |=> bus_req && $stable(bus_cmd) && $stable(bus_addr)); // R11
    AST_SNOOP_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q == PS_IDLE) && snp_valid |=> (fsm_q == PS_IDLE)); // R10
    AST_VICTIM_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && bus_gnt && (bus_cmd != BC_WBACK) |-> !((line_st == LS_EXC) && (line_tag != req_tag))); // R5

endmodule

// File: rtl/snoopy_wb_ctrl.sv
// Top level of the per-cache coherence controller. It ties the line store,
// the processor sequencer and the snoop responder together. The store is
// read by the processor address on port A and by the snooped address on
// port B. The snoop state update takes precedence at the store.
module snoopy_wb_ctrl
    import snc_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int IDX_W  = 2,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_done,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              bus_req,
    output logic [1:0]        bus_cmd,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_gnt,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              snp_valid,
    input  logic [1:0]        snp_cmd,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic              snp_abort,
    output logic [DATA_W-1:0] snp_data
);
    localparam int TAG_W = ADDR_W - IDX_W;

    logic [TAG_W-1:0]  a_tag, b_tag;
    line_st_t          a_st, b_st, wr_st_val, upd_st;
    logic [DATA_W-1:0] a_data, b_data, wr_data_val;
    logic              wr_st, wr_tag, wr_data, upd_we;
    bus_cmd_t          cmd_int;

    assign bus_cmd = cmd_int;

    snc_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .a_idx(cpu_addr[IDX_W-1:0]), .a_tag(a_tag), .a_st(a_st), .a_data(a_data),
        .a_we_st(wr_st), .a_we_tag(wr_tag), .a_we_data(wr_data),
        .a_wst(wr_st_val), .a_wtag(cpu_addr[ADDR_W-1:IDX_W]), .a_wdata(wr_data_val),
        .b_idx(snp_addr[IDX_W-1:0]), .b_tag(b_tag), .b_st(b_st), .b_data(b_data),
        .b_we_st(upd_we), .b_wst(upd_st)
    );

    snc_proc_fsm #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_proc (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_done(cpu_done), .cpu_rdata(cpu_rdata), .snp_valid(snp_valid),
        .line_tag(a_tag), .line_st(a_st), .line_data(a_data),
        .bus_req(bus_req), .bus_cmd(cmd_int), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_gnt(bus_gnt), .bus_rdata(bus_rdata),
        .wr_st(wr_st), .wr_tag(wr_tag), .wr_data(wr_data),
        .wr_st_val(wr_st_val), .wr_data_val(wr_data_val)
    );

    snc_snoop #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_snoop (
        .clk(clk), .rst_n(rst_n),
        .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr),
        .line_tag(b_tag), .line_st(b_st), .line_data(b_data),
        .upd_we(upd_we), .upd_st(upd_st), .snp_abort(snp_abort), .snp_data(snp_data)
    );

endmodule

// File: tb/snoopy_wb_ctrl_test.sv
// Bench: a behavioural model advanced on each rising edge predicts every
// output. Inputs change 1 ns after the falling edge (grant at 2 ns), and
// outputs are compared at 3 ns.
`timescale 1ns/1ps
module snoopy_wb_ctrl_test;
    localparam int AW = 12, DW = 16, IW = 2, NL = 1 << IW;

    logic clk = 1'b0, rst_n = 1'b0;
    always #5 clk = ~clk;

    logic          cpu_req = 0, cpu_we = 0, bus_gnt = 0, snp_valid = 0;
    logic [AW-1:0] cpu_addr = '0, snp_addr = '0;
    logic [DW-1:0] cpu_wdata = '0, bus_rdata;
    logic [1:0]    snp_cmd = '0;
    logic          cpu_done, bus_req, snp_abort;
    logic [DW-1:0] cpu_rdata, bus_wdata, snp_data;
    logic [1:0]    bus_cmd;
    logic [AW-1:0] bus_addr;

    snoopy_wb_ctrl #(.ADDR_W(AW), .IDX_W(IW), .DATA_W(DW)) uut (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_done(cpu_done), .cpu_rdata(cpu_rdata), .bus_req(bus_req),
        .bus_cmd(bus_cmd), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_gnt(bus_gnt),
        .bus_rdata(bus_rdata), .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr),
        .snp_abort(snp_abort), .snp_data(snp_data));

    logic [DW-1:0] mem [1 << AW];
    assign bus_rdata = mem[bus_addr];

    int checks = 0, errors = 0;
    int gdelay = 0, gcnt = 0;
    int txq[$];

    // Model state: 0 Invalid, 1 Shared, 2 Exclusive.
    int            mst [NL];
    int            mtag[NL];
    logic [DW-1:0] mdat[NL];
    int            mph = 0;
    logic [DW-1:0] mrd = '0;

    task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", r, act, exp);
        end
    endtask

    // Model advance at each rising edge.
    always @(posedge clk) begin
        int ri, rt, si, st, nst;
        logic sw, vd, hit;
        ri = int'(cpu_addr) % NL; rt = int'(cpu_addr) / NL;
        si = int'(snp_addr) % NL; st = int'(snp_addr) / NL;
        if (!rst_n) begin
            for (int i = 0; i < NL; i++) mst[i] = 0;
            mph = 0;
        end else begin
            sw = 0; nst = mst[si];
            if (snp_valid && mst[si] != 0 && mtag[si] == st) begin
                if (snp_cmd == 2'b01 && mst[si] == 2) begin sw = 1; nst = 1; end
                if (snp_cmd == 2'b10) begin sw = 1; nst = 0; end
            end
            vd = (mst[ri] == 2) && (mtag[ri] != rt);
            case (mph)
                0: if (cpu_req && !snp_valid) begin
                    hit = cpu_we ? (mst[ri] == 2 && mtag[ri] == rt) : (mst[ri] != 0 && mtag[ri] == rt);
                    if (hit) begin
                        if (cpu_we) mdat[ri] = cpu_wdata; else mrd = mdat[ri];
                        mph = 3;
                    end else mph = vd ? 1 : 2;
                end
                1: if (!vd) mph = 2; else if (bus_gnt) begin mst[ri] = 0; mph = 2; end
                2: if (bus_gnt) begin
                    mtag[ri] = rt; mst[ri] = cpu_we ? 2 : 1;
                    mdat[ri] = cpu_we ? cpu_wdata : mem[cpu_addr];
                    if (!cpu_we) mrd = mem[cpu_addr];
                    mph = 3;
                end
                default: mph = 0;
            endcase
            if (sw) mst[si] = nst;
        end
    end

    // Grant source: counts request cycles, never grants in a snoop cycle.
    always begin
        @(negedge clk); #2;
        if (bus_req && !snp_valid) begin
            if (gcnt >= gdelay) begin bus_gnt = 1; gcnt = 0; end
            else begin bus_gnt = 0; gcnt++; end
        end else bus_gnt = 0;
    end

    // Per-cycle comparison against the model, plus transaction log and memory.
    always begin
        int ri, rt, si, st;
        logic vd, ereq, eab;
        @(negedge clk); #3;
        if (rst_n) begin
            ri = int'(cpu_addr) % NL; rt = int'(cpu_addr) / NL;
            si = int'(snp_addr) % NL; st = int'(snp_addr) / NL;
            vd = (mst[ri] == 2) && (mtag[ri] != rt);
            ereq = (mph == 1 && vd) || mph == 2;
            chk("R11 bus_req", 32'(bus_req), 32'(ereq));
            if (ereq && bus_req) begin
                chk("R2 R3 R5 R6 bus_cmd", 32'(bus_cmd), (mph == 1) ? 3 : (cpu_we ? 2 : 1));
                chk("R2 R3 R5 R6 bus_addr", 32'(bus_addr), (mph == 1) ? 32'(mtag[ri] * NL + ri) : 32'(cpu_addr));
                chk("R5 R6 bus_wdata", 32'(bus_wdata), (mph == 1) ? 32'(mdat[ri]) : 0);
            end
            chk("R4 R11 cpu_done", 32'(cpu_done), 32'(mph == 3));
            if (mph == 3 && !cpu_we) chk("R2 R4 cpu_rdata", 32'(cpu_rdata), 32'(mrd));
            eab = snp_valid && (snp_cmd == 2'b01 || snp_cmd == 2'b10) && mst[si] == 2 && mtag[si] == st;
            chk("R7 R8 R9 snp_abort", 32'(snp_abort), 32'(eab));
            chk("R7 R8 R9 snp_data", 32'(snp_data), eab ? 32'(mdat[si]) : 0);
            if (bus_req && bus_gnt) begin
                txq.push_back(int'(bus_cmd));
                if (bus_cmd == 2'b11) mem[bus_addr] = bus_wdata;
            end
        end
    end

    task automatic cpu_op(input logic we, input logic [AW-1:0] a, input logic [DW-1:0] d,
                          output logic [DW-1:0] rd, output int lat);
        @(negedge clk); #1;
        cpu_req = 1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
        lat = 0;
        forever begin
            @(negedge clk); #1;
            lat++;
            if (cpu_done) break;
        end
        rd = cpu_rdata;
        cpu_req = 0;
    endtask

    task automatic snoop(input logic [1:0] c, input logic [AW-1:0] a, output logic ab, output logic [DW-1:0] sd);
        @(negedge clk); #1;
        snp_valid = 1; snp_cmd = c; snp_addr = a;
        #2; ab = snp_abort; sd = snp_data;
        @(negedge clk); #1;
        snp_valid = 0; snp_cmd = 0;
    endtask

    task automatic chk_tx(input string r, input int n, input int c0, input int c1);
        chk({r, " tx count"}, 32'(txq.size()), 32'(n));
        if (n > 0 && txq.size() > 0) chk({r, " tx first"}, 32'(txq[0]), 32'(c0));
        if (n > 1 && txq.size() > 1) chk({r, " tx second"}, 32'(txq[1]), 32'(c1));
        txq.delete();
    endtask

    localparam logic [AW-1:0] A = 12'h010, B = 12'h020, C = 12'h011, D = 12'h051, E = 12'h032;

    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL R11 watchdog actual hung expected done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [DW-1:0] rd, sd;
        int lat;
        logic ab;
        for (int i = 0; i < (1 << AW); i++) mem[i] = DW'(i * 37 + 16'h1100);
        repeat (3) @(negedge clk);
        #1 rst_n = 1;
        @(negedge clk); #3;
        // R1: quiet outputs after reset
        chk("R1 bus_req", 32'(bus_req), 0);
        chk("R1 cpu_done", 32'(cpu_done), 0);
        chk("R1 snp_abort", 32'(snp_abort), 0);
        txq.delete();
        // R1 R2: first read misses and fills Shared
        cpu_op(0, A, 0, rd, lat);
        chk_tx("R1 R2", 1, 1, 0);
        chk("R2 fill data", 32'(rd), 32'(mem[A]));
        cpu_op(0, A, 0, rd, lat);
        chk_tx("R4 read hit", 0, 0, 0);
        chk("R4 hit latency", 32'(lat), 1);
        // R3: write to Shared is a write miss
        cpu_op(1, A, 16'hBEEF, rd, lat);
        chk_tx("R3 write on shared", 1, 2, 0);
        cpu_op(1, A, 16'h1234, rd, lat);
        chk_tx("R4 write hit", 0, 0, 0);
        cpu_op(0, A, 0, rd, lat);
        chk("R4 read exclusive", 32'(rd), 32'h1234);
        // R5: dirty victim on read miss
        cpu_op(0, B, 0, rd, lat);
        chk_tx("R5", 2, 3, 1);
        chk("R5 victim in memory", 32'(mem[A]), 32'h1234);
        cpu_op(1, A, 16'h5555, rd, lat);
        chk_tx("R3 clean victim", 1, 2, 0);
        // R6: dirty victim on write miss
        cpu_op(1, B, 16'h6666, rd, lat);
        chk_tx("R6", 2, 3, 2);
        chk("R6 victim in memory", 32'(mem[A]), 32'h5555);
        cpu_op(0, B, 0, rd, lat);
        chk("R6 new data", 32'(rd), 32'h6666);
        txq.delete();
        // R7: snooped read miss on Exclusive
        snoop(2'b01, B, ab, sd);
        chk("R7 abort", 32'(ab), 1);
        chk("R7 data", 32'(sd), 32'h6666);
        cpu_op(0, B, 0, rd, lat);
        chk_tx("R7 still readable", 0, 0, 0);
        cpu_op(1, B, 16'h7777, rd, lat);
        chk_tx("R7 now shared", 1, 2, 0);
        // R8: snooped write miss on Exclusive then on Shared
        snoop(2'b10, B, ab, sd);
        chk("R8 abort exclusive", 32'(ab), 1);
        chk("R8 data", 32'(sd), 32'h7777);
        cpu_op(0, B, 0, rd, lat);
        chk_tx("R8 invalidated", 1, 1, 0);
        snoop(2'b10, B, ab, sd);
        chk("R8 no abort shared", 32'(ab), 0);
        cpu_op(0, B, 0, rd, lat);
        chk_tx("R8 shared invalidated", 1, 1, 0);
        // R9: mismatched tag, invalid line, read on Shared
        snoop(2'b01, A, ab, sd);
        chk("R9 other tag", 32'(ab), 0);
        snoop(2'b10, E, ab, sd);
        chk("R9 invalid line", 32'(ab), 0);
        snoop(2'b01, B, ab, sd);
        chk("R9 shared read", 32'(ab), 0);
        cpu_op(0, B, 0, rd, lat);
        chk_tx("R9 line kept", 0, 0, 0);
        // R10: snoop in the acceptance cycle defers the request
        fork
            cpu_op(0, C, 0, rd, lat);
            snoop(2'b10, D, ab, sd);
        join
        chk("R10 deferred latency", 32'(lat), 3);
        chk_tx("R10", 1, 1, 0);
        // R12: victim cleaned by a snoop while waiting for the write-back grant
        cpu_op(1, A, 16'h9999, rd, lat);
        txq.delete();
        gdelay = 4; gcnt = 0;
        fork
            cpu_op(0, B, 0, rd, lat);
            begin
                repeat (1) @(negedge clk);
                snoop(2'b01, A, ab, sd);
            end
        join
        chk("R12 snoop abort", 32'(ab), 1);
        chk_tx("R12 write-back dropped", 1, 1, 0);
        chk("R12 fill", 32'(rd), 32'(mem[B]));
        // R11: request held through a delayed grant
        gdelay = 3; gcnt = 0;
        cpu_op(0, E, 0, rd, lat);
        chk("R11 latency", 32'(lat), 5);
        chk_tx("R11", 1, 1, 0);
        gdelay = 0;
        repeat (3) @(negedge clk);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule